// File: doc/BRIEF.md
# Shared Shift-Append Codec PE Chain

This block packs up to sixteen variable-length per-coefficient codes into one bitstream in a single cycle. It can also unpack them again. Encoding and decoding use the same chain of processing elements (PEs), and a mode input selects between them. The PEs form two arrays of eight: an upper array for codes 0 to 7 and a lower array for codes 8 to 15. Splitting the chain this way keeps the stream that any one PE has to shift down to 24 bits.

Every PE shifts its running stream right by its own code length, and this shift is the same in both modes.
- **Encode:** after the shift, the PE drops its code into the vacated left end. A combine shifter then joins the upper and lower results into one stream, right-aligned, with the first code at the LSB.
- **Decode:** before the shift, the PE picks its code off the right end. A split shifter moves the incoming stream on by the upper array's total length before it reaches the lower array.

Code lengths come from outside the block, from the significance logic, and are applied the same way in both modes. Four cycles of sixteen codes cover a 64-coefficient coding pass. All results are registered once per cycle.

Top module: `codec_pe_chain`

## Requirements
- R1: While reset is asserted and after its release, out_valid, out_stream, out_codes and out_len are all zero.
- R2: Inputs taken with in_valid high appear on the outputs at the next rising edge with out_valid high. A cycle with in_valid low gives out_valid low on the next edge and leaves out_stream, out_codes and out_len unchanged.
- R3: In encode mode (dec_mode=0), code k (pe_bits[3k+2:3k], length pe_cnt[2k+1:2k]) lands in out_stream with its bit 0 at offset off_k. off_k is the sum of the lengths of codes 0 to k-1. In this mode out_codes is zero.
- R4: In encode mode, pe_bits bits at or above a code's length have no effect on out_stream, and a length of 0 contributes no bits.
- R5: out_len equals the sum of the sixteen code lengths (0 to 48) in both modes.
- R6: In encode mode, every out_stream bit at position out_len or above is zero.
- R7: In decode mode (dec_mode=1), out_codes[3k+2:3k] holds dec_stream bits off_k upward for pe_cnt[2k+1:2k] bits, zero-extended, and out_stream is zero.
- R8: In decode mode, dec_stream bits at position out_len or above have no effect on out_codes.
- R9: Decoding an encoded stream with the same lengths returns every code with the bits above its length cleared. This holds when codes cross the boundary between the upper and lower arrays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| dec_mode | input | 1 | 0 = encode, 1 = decode |
| pe_cnt | input | 32 | Sixteen 2-bit code lengths, code k at [2k+1:2k] |
| pe_bits | input | 48 | Sixteen 3-bit codes to encode, code k at [3k+2:3k] |
| dec_stream | input | 48 | Stream to decode, first code at the LSB |
| out_valid | output | 1 | Registered results are valid |
| out_stream | output | 48 | Packed stream (encode), zero in decode |
| out_codes | output | 48 | Extracted codes (decode), zero in encode |
| out_len | output | 6 | Total bits packed or consumed |

## Verification
The assertions take each 2-bit length as at most 3, the widest code a PE holds. They also take in_valid and dec_mode as steady around the sampling edge. The stimulus draws every length from 0 to 3 with $urandom and fills the bits above each code and above the stream length with random garbage. Directed cases cover the all-zero and all-full lengths, a single code at the last PE, and loopback runs in which the upper array's total falls at odd positions.

// File: rtl/codec_pe_chain.sv
module codec_pe_chain #(
  parameter int PES  = 8,
  parameter int MAXB = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          dec_mode,
  input  logic [2*PES*$clog2(MAXB+1)-1:0] pe_cnt,
  input  logic [2*PES*MAXB-1:0]         pe_bits,
  input  logic [2*PES*MAXB-1:0]         dec_stream,
  output logic                          out_valid,
  output logic [2*PES*MAXB-1:0]         out_stream,
  output logic [2*PES*MAXB-1:0]         out_codes,
  output logic [$clog2(2*PES*MAXB+1)-1:0] out_len
);
  localparam int CW = $clog2(MAXB+1);
  localparam int AW = PES*MAXB;
  localparam int SW = 2*AW;
  localparam int LW = $clog2(SW+1);

  function automatic logic [MAXB-1:0] low_mask(input logic [CW-1:0] n);
    logic [MAXB:0] t;
    t = ((MAXB+1)'(1) << n) - (MAXB+1)'(1);
    return t[MAXB-1:0];
  endfunction

  logic [SW-1:0] merged, codes_n;
  logic [LW-1:0] total;
  logic          dec_q;

  always_comb begin
    logic [AW-1:0]   s;
    logic [CW-1:0]   c;
    logic [MAXB-1:0] m, b;
    logic [LW-1:0]   cnt_a, cnt_u;
    merged  = '0;
    codes_n = '0;
    cnt_u   = '0;
    total   = '0;
    for (int a = 0; a < 2; a++) begin
      s     = dec_mode ? AW'(dec_stream >> cnt_u) : '0;
      cnt_a = '0;
      for (int k = 0; k < PES; k++) begin
        c = pe_cnt[(a*PES+k)*CW +: CW];
        m = low_mask(c);
        b = pe_bits[(a*PES+k)*MAXB +: MAXB] & m;
        if (dec_mode) begin
          codes_n[(a*PES+k)*MAXB +: MAXB] = s[MAXB-1:0] & m;
          s = s >> c;
        end else begin
          s = (s >> c) | (AW'(b) << (AW - int'(c)));
        end
        cnt_a = cnt_a + LW'(c);
      end
      if (!dec_mode)
        merged = merged | ((SW'(s) >> (AW - int'(cnt_a))) << cnt_u);
      if (a == 0) cnt_u = cnt_a;
      total = total + cnt_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_stream <= '0;
      out_codes  <= '0;
      out_len    <= '0;
      dec_q      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_stream <= dec_mode ? '0 : merged;
        out_codes  <= dec_mode ? codes_n : '0;
        out_len    <= total;
        dec_q      <= dec_mode;
      end
    end

  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_stream) && $stable(out_len) && $stable(out_codes));
  a_r5_len_max: assert property (@(posedge clk) disable iff (!rst_n)
    out_len <= LW'(SW));
  a_r6_clean_top: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !dec_q |-> (out_stream >> out_len) == '0);
  a_r3_enc_no_codes: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !dec_q |-> out_codes == '0 && $countones(out_stream) <= int'(out_len));
  a_r7_dec_no_stream: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && dec_q |-> out_stream == '0 && $countones(out_codes) <= int'(out_len));
endmodule

// File: tb/test_codec_pe_chain.sv
module test_codec_pe_chain;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, in_valid = 0, dec_mode = 0;
  logic [31:0] pe_cnt = '0;
  logic [47:0] pe_bits = '0, dec_stream = '0;
  logic        out_valid;
  logic [47:0] out_stream, out_codes;
  logic [5:0]  out_len;

  int tests = 0, fails = 0;
  bit done = 0;

  codec_pe_chain i_codec_pe_chain (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [47:0] ref_enc(input logic [31:0] cn, input logic [47:0] bt);
    logic [47:0] s = '0;
    int off = 0;
    for (int k = 0; k < 16; k++) begin
      for (int j = 0; j < int'(cn[2*k +: 2]); j++) s[off+j] = bt[3*k+j];
      off += int'(cn[2*k +: 2]);
    end
    return s;
  endfunction

  function automatic logic [47:0] ref_dec(input logic [31:0] cn, input logic [47:0] st);
    logic [47:0] r = '0;
    int off = 0;
    for (int k = 0; k < 16; k++) begin
      for (int j = 0; j < int'(cn[2*k +: 2]); j++) r[3*k+j] = st[off+j];
      off += int'(cn[2*k +: 2]);
    end
    return r;
  endfunction

  function automatic logic [5:0] ref_len(input logic [31:0] cn);
    int t = 0;
    for (int k = 0; k < 16; k++) t += int'(cn[2*k +: 2]);
    return 6'(t);
  endfunction

  function automatic logic [47:0] masked(input logic [31:0] cn, input logic [47:0] bt);
    return ref_dec(cn, ref_enc(cn, bt));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic d, input logic [31:0] cn, input logic [47:0] bt, input logic [47:0] st);
    dec_mode = d; pe_cnt = cn; pe_bits = bt; dec_stream = st; in_valid = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
  endtask

  task automatic enc_check(input logic [31:0] cn, input logic [47:0] bt);
    apply(0, cn, bt, $urandom);
    chk("R2 valid", 64'(out_valid), 1);
    chk("R3 R4 encode stream", 64'(out_stream), 64'(ref_enc(cn, bt)));
    chk("R5 encode len", 64'(out_len), 64'(ref_len(cn)));
  endtask

  task automatic dec_check(input logic [31:0] cn, input logic [47:0] st);
    apply(1, cn, $urandom, st);
    chk("R7 decode codes", 64'(out_codes), 64'(ref_dec(cn, st)));
    chk("R7 decode stream zero", 64'(out_stream), 0);
    chk("R5 decode len", 64'(out_len), 64'(ref_len(cn)));
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] cn;
    logic [47:0] bt, st, g;
    void'($urandom(32'h5EED));
    @(negedge clk);
    chk("R1 reset valid", 64'(out_valid), 0);
    chk("R1 reset stream", 64'(out_stream), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset codes", 64'(out_codes), 0);
    chk("R1 after reset len", 64'(out_len), 0);

    // R4: all lengths zero, garbage bits
    enc_check('0, 48'hFFFF_FFFF_FFFF);
    // R5: all lengths three, full stream
    enc_check('1, 48'h9A3C_5F01_7E24);
    // R3: only the last PE carries a code
    enc_check(32'hC000_0000, 48'hE000_0000_0000);
    chk("R3 last code at bit 0", 64'(out_stream), 64'h7);
    // R3: code 8 follows upper array exactly
    enc_check(32'h0001_5555, 48'hFFFF_FFFF_FFFF);
    chk("R6 top bits zero", 64'(out_stream >> out_len), 0);

    // R2: idle cycle holds outputs
    bt = out_stream;
    dec_mode = 1; pe_cnt = '1; in_valid = 0;
    @(posedge clk); @(negedge clk);
    chk("R2 idle valid low", 64'(out_valid), 0);
    chk("R2 idle stream held", 64'(out_stream), 64'(bt));

    // R8: garbage above length ignored
    cn = 32'h0000_0007;
    dec_check(cn, 48'h0000_0000_001D);
    bt = out_codes;
    dec_check(cn, 48'hFFFF_FFFF_FFFD);
    chk("R8 garbage ignored", 64'(out_codes), 64'(bt));

    for (int i = 0; i < 300; i++) begin
      cn = $urandom; bt = {16'($urandom), 32'($urandom)};
      enc_check(cn, bt);
      chk("R6 top bits zero", 64'(out_stream >> out_len), 0);
      st = out_stream;
      g = {16'($urandom), 32'($urandom)};
      if (out_len < 48) st = st | (g << out_len);
      dec_check(cn, st);
      chk("R9 loopback codes", 64'(out_codes), 64'(masked(cn, bt)));
    end

    for (int i = 0; i < 200; i++)
      dec_check($urandom, {16'($urandom), 32'($urandom)});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule